// File: doc/BRIEF.md
# Audio clock generator

This block produces the frame clock and the bit clock of a stereo serial audio port. In the three master speed modes it divides its reference down to a frame clock at the sample rate Fs and a bit clock at 64×Fs, and it drives both pins. In slave mode it releases both pins and passes the externally supplied clocks, after synchronisation, to the internal consumers. A strap input engages a divide-by-two prescaler, so each speed mode accepts two master-clock-to-Fs ratios.

The block runs from a single reference clock `clk` at twice the master clock rate. This lets every division ratio, including a bit clock equal to the master clock, be built from plain registers with a 50% duty cycle. Every output is registered on the rising edge of `clk`.

The block also tells the serial transmitter where it is in the frame. It gives a bit-slot index, 0 to 63, that steps on each falling edge of the bit clock, and a channel flag that is 0 for left and 1 for right.

Top module: `aclk_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, after that edge `sclk_o`, `lrck_o`, `int_sclk`, `int_lrck`, `bit_slot` and `chan_right` are all 0.
- R2: `mode_sel` codes 2'b00, 2'b01 and 2'b10 select master single, double and quad speed, and `sclk_oe`/`lrck_oe` are 1. Code 2'b11 selects slave, and both enables are 0.
- R3: In master mode with `fast_mclk`=0, the bit clock stays low for H `clk` cycles and then high for H cycles, where H is 4 (single), 2 (double) or 1 (quad).
- R4: In master mode the frame clock is low for the first 32 bit periods of each 64-bit frame and high for the next 32, and `chan_right` equals the frame clock.
- R5: In master mode every frame clock change falls on the same `clk` edge as a bit clock falling edge.
- R6: With `fast_mclk`=1 in a master mode, H is doubled (8, 4, 2), which doubles every bit and frame period.
- R7: Counting the rising edges of `clk` with `rst_n` high from the release of reset, the bit clock first rises after exactly H edges and the frame clock first rises after exactly 64×H edges.
- R8: In master mode `bit_slot` is 0 at the start of a frame. It increments by one on the edge where the bit clock falls, wrapping from 63 to 0, and holds otherwise.
- R9: In slave mode `sclk_o` and `lrck_o` stay 0, and `int_sclk`/`int_lrck` equal `ext_sclk`/`ext_lrck` as sampled two rising edges earlier.
- R10: In slave mode `bit_slot` changes one edge after the synchronised bit clock is seen to fall. It becomes 0 if the synchronised frame clock fell at the same point, and otherwise increments modulo 64. `chan_right` equals `int_lrck`.
- R11: In slave mode `fast_mclk` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the master clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Speed and clocking mode strap |
| fast_mclk | input | 1 | Engages the divide-by-two prescaler |
| ext_sclk | input | 1 | Bit clock from the pin in slave mode |
| ext_lrck | input | 1 | Frame clock from the pin in slave mode |
| sclk_o | output | 1 | Bit clock pin value in master mode |
| sclk_oe | output | 1 | Bit clock pin drive enable |
| lrck_o | output | 1 | Frame clock pin value in master mode |
| lrck_oe | output | 1 | Frame clock pin drive enable |
| int_sclk | output | 1 | Bit clock for internal consumers |
| int_lrck | output | 1 | Frame clock for internal consumers |
| bit_slot | output | 6 | Bit position within the frame |
| chan_right | output | 1 | 1 while the right channel is active |

## Verification
In master mode the bit clock changes after every H counted edges from the release of reset, so the reference model counts released edges and derives every expected master output from that count alone. In slave mode the internal clocks lag the pins by two edges and the slot index moves three edges after a pin-side bit clock fall. The model keeps a short queue of pin values sampled at each rising edge and reads expectations from the right depth of that queue. Inputs change just after the falling edge and outputs are compared at the falling edge, so each comparison sees the state left by the preceding rising edge.

// File: rtl/aclk_pkg.sv
// Shared types and divide-ratio lookup for the audio clock generator.
// Assumes the reference clock runs at twice the master clock rate.
package aclk_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        CLK_SLAVE  = 2'b11
    } clk_mode_e;

    // Bit clock half-period in reference cycles before the prescaler.
    localparam logic [3:0] HALF_SINGLE = 4'd4;
    localparam logic [3:0] HALF_DOUBLE = 4'd2;
    localparam logic [3:0] HALF_QUAD   = 4'd1;

    // Half-period of the bit clock, in reference cycles, for a mode and strap.
    function automatic logic [3:0] half_period(clk_mode_e m, logic fast);
        logic [3:0] base;
        case (m)
            SPD_SINGLE: base = HALF_SINGLE;
            SPD_DOUBLE: base = HALF_DOUBLE;
            default:    base = HALF_QUAD;
        endcase
        return fast ? {base[2:0], 1'b0} : base;
    endfunction

endpackage

// File: rtl/aclk_tick_gen.sv
// Half-period tick generator: pulses tick once every half_len reference
// cycles. Assumes half_len >= 1 and is static while out of reset.
module aclk_tick_gen #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] half_len,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == half_len - 1'b1);

    // Count reference cycles within one bit clock half-period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/aclk_phase_ctr.sv
// Frame phase counter: counts bit clock half-periods across one frame.
// The LSB is the bit clock (low first), the MSB is the frame clock, and
// the bits between form the slot index. Assumes tick from aclk_tick_gen.
module aclk_phase_ctr #(
    parameter int SLOT_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    output logic                 gen_sclk,
    output logic                 gen_lrck,
    output logic [SLOT_BITS-1:0] gen_slot
);
    localparam int PH_W = SLOT_BITS + 1;

    logic [PH_W-1:0] phase;

    // Advance one half-period per tick, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= phase + 1'b1;
    end

    assign gen_sclk = phase[0];
    assign gen_lrck = phase[PH_W-1];
    assign gen_slot = phase[PH_W-1:1];
endmodule

// File: rtl/aclk_slave_track.sv
// Slave-side tracker: synchronises the external bit and frame clocks into
// the reference domain and derives a slot index from them. Assumes the
// external bit clock half-period spans at least two reference cycles.
module aclk_slave_track #(
    parameter int SLOT_BITS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_sclk,
    input  logic                 ext_lrck,
    output logic                 trk_sclk,
    output logic                 trk_lrck,
    output logic [SLOT_BITS-1:0] trk_slot
);
    localparam int NSIG = 2;

    logic [NSIG-1:0]        pin_in;
    logic [SYNC_STAGES-1:0] sync_q [NSIG];
    logic                   sclk_prev, lrck_prev;
    logic                   sclk_fall, lrck_fall;

    assign pin_in = {ext_lrck, ext_sclk};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        // Shift one pin through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= '0;
            else        sync_q[g] <= {sync_q[g][SYNC_STAGES-2:0], pin_in[g]};
        end
    end

    assign trk_sclk  = sync_q[0][SYNC_STAGES-1];
    assign trk_lrck  = sync_q[1][SYNC_STAGES-1];
    assign sclk_fall = sclk_prev & ~trk_sclk;
    assign lrck_fall = lrck_prev & ~trk_lrck;

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            lrck_prev <= 1'b0;
        end else begin
            sclk_prev <= trk_sclk;
            lrck_prev <= trk_lrck;
        end
    end

    // Step the slot on each bit clock fall; restart it at a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         trk_slot <= '0;
        else if (sclk_fall) trk_slot <= lrck_fall ? '0 : trk_slot + 1'b1;
    end
endmodule

// File: rtl/aclk_gen.sv
// Audio clock generator top. It derives the bit and frame clocks from the
// reference in the master modes, or tracks the external clocks in slave
// mode, and gives slot and channel information to the serial port.
// Assumes mode_sel and fast_mclk change only while rst_n is low.
module aclk_gen #(
    parameter int SLOT_BITS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_sel,
    input  logic                 fast_mclk,
    input  logic                 ext_sclk,
    input  logic                 ext_lrck,
    output logic                 sclk_o,
    output logic                 sclk_oe,
    output logic                 lrck_o,
    output logic                 lrck_oe,
    output logic                 int_sclk,
    output logic                 int_lrck,
    output logic [SLOT_BITS-1:0] bit_slot,
    output logic                 chan_right
);
    import aclk_pkg::*;

    localparam int CNT_W = 4;

    clk_mode_e            mode;
    logic                 is_slave;
    logic [CNT_W-1:0]     half_len;
    logic                 tick;
    logic                 gen_sclk, gen_lrck;
    logic [SLOT_BITS-1:0] gen_slot;
    logic                 trk_sclk, trk_lrck;
    logic [SLOT_BITS-1:0] trk_slot;

    assign mode     = clk_mode_e'(mode_sel);
    assign is_slave = (mode == CLK_SLAVE);
    assign half_len = half_period(mode, fast_mclk);

    aclk_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_len (half_len),
        .tick     (tick)
    );

    aclk_phase_ctr #(.SLOT_BITS(SLOT_BITS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gen_sclk (gen_sclk),
        .gen_lrck (gen_lrck),
        .gen_slot (gen_slot)
    );

    aclk_slave_track #(.SLOT_BITS(SLOT_BITS), .SYNC_STAGES(SYNC_STAGES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_sclk (ext_sclk),
        .ext_lrck (ext_lrck),
        .trk_sclk (trk_sclk),
        .trk_lrck (trk_lrck),
        .trk_slot (trk_slot)
    );

    // Pin drivers: driven in master modes, released and quiet in slave.
    always_comb begin
        sclk_oe = ~is_slave;
        lrck_oe = ~is_slave;
        sclk_o  = is_slave ? 1'b0 : gen_sclk;
        lrck_o  = is_slave ? 1'b0 : gen_lrck;
    end

    // Internal consumers: generated clocks in master, tracked ones in slave.
    always_comb begin
        int_sclk   = is_slave ? trk_sclk : gen_sclk;
        int_lrck   = is_slave ? trk_lrck : gen_lrck;
        bit_slot   = is_slave ? trk_slot : gen_slot;
        chan_right = int_lrck;
    end
endmodule

// File: rtl/aclk_gen_chk.sv
// Assertion checker for aclk_gen, attached through bind below.
module aclk_gen_chk #(
    parameter int SLOT_BITS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode_sel,
    input logic                 fast_mclk,
    input logic                 ext_sclk,
    input logic                 ext_lrck,
    input logic                 sclk_o,
    input logic                 sclk_oe,
    input logic                 lrck_o,
    input logic                 lrck_oe,
    input logic                 int_sclk,
    input logic                 int_lrck,
    input logic [SLOT_BITS-1:0] bit_slot,
    input logic                 chan_right
);
    logic       rst_d = 1'b1;
    logic [1:0] since_rst = 2'd0;
    logic       master;

    assign master = (mode_sel != 2'b11);

    // Track the reset level at the previous edge and released edges since.
    always @(posedge clk) begin
        rst_d <= rst_n;
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_d) begin
            reset_idle_chk: assert (!sclk_o && !lrck_o && !int_sclk && !int_lrck
                                    && bit_slot == '0 && !chan_right)
                else $error("reset state not idle");
        end
    end

    // R2
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (!sclk_oe && !lrck_oe && !sclk_o && !lrck_o));

    // R5
    lrck_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && lrck_o != $past(lrck_o)) |-> $fell(sclk_o));

    // R8
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $fell(sclk_o)) |-> (bit_slot == $past(bit_slot) + 1'b1));

    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !$fell(sclk_o)) |-> $stable(bit_slot));

    // R4
    chan_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master |-> (chan_right == lrck_o));

    // R9
    slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && since_rst == 2'd3)
            |-> (int_sclk == $past(ext_sclk, 2) && int_lrck == $past(ext_lrck, 2)));
endmodule

bind aclk_gen aclk_gen_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (.*);

// File: tb/aclk_gen_tb.sv
// Self-checking bench for aclk_gen with a behavioural reference model.
module aclk_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       fast_mclk = 1'b0;
    logic       ext_sclk = 1'b0;
    logic       ext_lrck = 1'b0;
    logic       sclk_o, sclk_oe, lrck_o, lrck_oe, int_sclk, int_lrck, chan_right;
    logic [5:0] bit_slot;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  run_chk = 0;
    bit  done = 0;
    int  n_edges = 0;
    int  sslot = 0;
    bit  q_s[$];
    bit  q_l[$];

    aclk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fast_mclk(fast_mclk),
        .ext_sclk(ext_sclk), .ext_lrck(ext_lrck), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .lrck_o(lrck_o), .lrck_oe(lrck_oe), .int_sclk(int_sclk), .int_lrck(int_lrck),
        .bit_slot(bit_slot), .chan_right(chan_right)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int half_of(logic [1:0] m, logic f);
        int b;
        b = (m == 2'b00) ? 4 : (m == 2'b01) ? 2 : 1;
        return f ? 2 * b : b;
    endfunction

    task automatic chk(string tag, int got, int exp, string what);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Reference model state: released edges and pin history per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            n_edges = 0;
            sslot   = 0;
            q_s     = '{0, 0, 0};
            q_l     = '{0, 0, 0};
        end else begin
            n_edges++;
            q_s.push_back(ext_sclk);
            q_l.push_back(ext_lrck);
            if (q_s[$-3] && !q_s[$-2])
                sslot = (q_l[$-3] && !q_l[$-2]) ? 0 : (sslot + 1) % 64;
            if (q_s.size() > 8) begin
                void'(q_s.pop_front());
                void'(q_l.pop_front());
            end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (run_chk) begin
            if (mode_sel != 2'b11) begin
                int h, hp;
                h  = half_of(mode_sel, fast_mclk);
                hp = (n_edges / h) % 128;
                chk("R3", sclk_o, hp % 2, "sclk_o (R1 R6 R7)");
                chk("R4", lrck_o, hp / 64, "lrck_o (R1 R7)");
                chk("R4", chan_right, hp / 64, "chan_right");
                chk("R8", bit_slot, (hp / 2) % 64, "bit_slot");
                chk("R2", {sclk_oe, lrck_oe}, 3, "pin enables");
                chk("R5", int_sclk, hp % 2, "int_sclk");
                chk("R5", int_lrck, hp / 64, "int_lrck");
            end else begin
                chk("R9", {sclk_o, lrck_o}, 0, "pins quiet (R11)");
                chk("R2", {sclk_oe, lrck_oe}, 0, "pin enables");
                chk("R9", int_sclk, q_s[$-1], "int_sclk");
                chk("R9", int_lrck, q_l[$-1], "int_lrck");
                chk("R10", bit_slot, sslot, "slave bit_slot (R11)");
                chk("R10", chan_right, q_l[$-1], "slave chan_right");
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_reset(logic [1:0] m, logic f);
        step(1);
        rst_n     = 1'b0;
        mode_sel  = m;
        fast_mclk = f;
        ext_sclk  = 1'b0;
        ext_lrck  = 1'b0;
        step(4);
        rst_n = 1'b1;
    endtask

    // R3 R4 R6 R7 R8: two full frames per master mode and strap.
    task automatic run_master(logic [1:0] m, logic f);
        do_reset(m, f);
        step(2 * 128 * half_of(m, f) + 5);
    endtask

    // R9 R10 R11: external clocks starting mid-frame, 3-cycle half-periods.
    task automatic run_slave(logic f, int start_bit);
        do_reset(2'b11, f);
        step(3);
        for (int b = start_bit; b < start_bit + 140; b++) begin
            ext_sclk = 1'b0;
            ext_lrck = ((b % 64) >= 32);
            step(3);
            ext_sclk = 1'b1;
            step(3);
        end
        step(6);
    endtask

    initial begin
        step(3);
        run_chk = 1;
        for (int m = 0; m < 3; m++) begin
            run_master(m[1:0], 1'b0);
            run_master(m[1:0], 1'b1);
        end
        run_slave(1'b0, 40);
        run_slave(1'b1, 10);
        run_master(2'b10, 1'b0);
        step(2);
        finish_up();
    end
endmodule